// File: doc/BRIEF.md
# Split Serial Buffer Pointer Controller

This block steers the address pointer of a 512-word by 8-bit serial buffer that sits beside a DRAM array. Each serial clock with the enable high moves the pointer on by one entry. Transfer events load a start (tap) address from the 9-bit column address of the transfer cycle. They also set the serial port direction: output after a read, input after a write or pseudo-write.

In split operation the buffer runs as a lower half (0-255) and an upper half (256-511). A split transfer stores a tap for the idle half and leaves the running pointer alone. When the pointer leaves the end of its partition, it jumps to the tap stored for the other half. A set-stop option cycle cuts each half into smaller partitions, and a clear-options cycle restores plain half boundaries. The storage array and the row data movement sit outside this block.

Top module: `sbp_ctrl`

## Requirements
- R1: After reset the pointer is 0, the upper-half flag is low and the port direction output is 0 (input).
- R2: A normal transfer (kind 0 read, 1 write, 2 pseudo-write) loads the pointer with the tap in the next cycle and leaves split mode.
- R3: With the serial enable high and no transfer, the pointer rises by one per clock; with the enable low and no transfer, it holds.
- R4: Outside split mode the pointer wraps from 511 to 0.
- R5: Kinds 0 and 3 (read, split read) set the port direction output to 1. Kinds 1, 2 and 4 (write, pseudo-write, split write) set it to 0.
- R6: A split transfer (kind 3 or 4) enters split mode and leaves the pointer unchanged. It stores the tap's low 8 bits for the half opposite the pointer's current half.
- R7: In split mode, an advance from the last entry of the active partition loads the tap stored for the other half.
- R8: The upper-half flag is 1 exactly while the pointer lies in 256-511.
- R9: When no split transfer has arrived since the last jump, the next jump goes to entry 0 of the other half.
- R10: A set-stop cycle with code k makes partitions of 256>>k entries in split mode (k = 0..4). Codes above 4 act as 4.
- R11: A clear-options cycle returns split mode to 256-entry half boundaries.
- R12: Transfer kinds 5 to 7 have no effect on the pointer or the port direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial enable; advance the pointer |
| xfer_valid | input | 1 | Transfer event this cycle |
| xfer_kind | input | 3 | Transfer kind code |
| xfer_tap | input | 9 | Tap (column) address of the transfer |
| opt_set_stop | input | 1 | Set-stop option cycle |
| opt_clear | input | 1 | Clear-options cycle |
| stop_code | input | 3 | Partition size code for set-stop |
| ptr | output | 9 | Current buffer pointer |
| upper_half | output | 1 | High while the upper half is active |
| port_is_out | output | 1 | 1 = serial port drives out, 0 = input |

## Verification
The bench builds the block with its defaults: 9 address bits and five stop levels. These settings reach the true 511-to-0 wrap, both half crossings at 255 and 511, a 64-entry stop partition, and the clamped 16-entry partition. The scenarios are long enough for the pointer to walk whole partitions, so each jump is observed at the exact advance where it happens.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

   typedef enum logic [2:0] {
      XK_READ   = 3'd0,
      XK_WRITE  = 3'd1,
      XK_PSEUDO = 3'd2,
      XK_SREAD  = 3'd3,
      XK_SWRITE = 3'd4
   } xfer_kind_e;

   function automatic logic kind_known(input logic [2:0] k);
      return (k <= 3'd4);
   endfunction

   function automatic logic kind_split(input logic [2:0] k);
      return (k == XK_SREAD) || (k == XK_SWRITE);
   endfunction

   function automatic logic kind_read(input logic [2:0] k);
      return (k == XK_READ) || (k == XK_SREAD);
   endfunction

endpackage

// File: rtl/sbp_mode_reg.sv
module sbp_mode_reg #(
   parameter int STOP_LEVELS = 5,
   parameter int CODE_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_valid,
   input  logic [2:0]        xfer_kind,
   input  logic              opt_set_stop,
   input  logic              opt_clear,
   input  logic [CODE_W-1:0] stop_code,
   output logic              split_on,
   output logic              stop_on,
   output logic [CODE_W-1:0] stop_sel,
   output logic              port_is_out
);
   import sbp_pkg::*;

   localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(STOP_LEVELS - 1);

   logic [CODE_W-1:0] code_lim;
   logic              known;

   assign code_lim = (stop_code > MAX_CODE) ? MAX_CODE : stop_code;
   assign known    = xfer_valid && kind_known(xfer_kind);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         split_on    <= 1'b0;
         port_is_out <= 1'b0;
      end else if (known) begin
         split_on    <= kind_split(xfer_kind);
         port_is_out <= kind_read(xfer_kind);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_on  <= 1'b0;
         stop_sel <= '0;
      end else if (opt_clear) begin
         stop_on  <= 1'b0;
      end else if (opt_set_stop) begin
         stop_on  <= 1'b1;
         stop_sel <= code_lim;
      end
   end

endmodule

// File: rtl/sbp_boundary.sv
module sbp_boundary #(
   parameter int ADDR_W      = 9,
   parameter int STOP_LEVELS = 5,
   parameter int CODE_W      = 3
) (
   input  logic [ADDR_W-1:0] ptr,
   input  logic              split_on,
   input  logic              stop_on,
   input  logic [CODE_W-1:0] stop_sel,
   output logic              at_edge
);
   localparam int HALF_W = ADDR_W - 1;

   logic [HALF_W-1:0] mask_tbl [STOP_LEVELS];
   logic [HALF_W-1:0] part_mask;

   for (genvar g = 0; g < STOP_LEVELS; g++) begin : g_mask
      assign mask_tbl[g] = {HALF_W{1'b1}} >> g;
   end

   always_comb begin
      part_mask = mask_tbl[0];
      for (int i = 0; i < STOP_LEVELS; i++) begin
         if (stop_on && (stop_sel == CODE_W'(i))) part_mask = mask_tbl[i];
      end
   end

   assign at_edge = split_on && ((ptr[HALF_W-1:0] & part_mask) == part_mask);

endmodule

// File: rtl/sbp_pointer.sv
module sbp_pointer #(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en,
   input  logic              at_edge,
   input  logic              xfer_valid,
   input  logic [2:0]        xfer_kind,
   input  logic [ADDR_W-1:0] xfer_tap,
   output logic [ADDR_W-1:0] ptr
);
   import sbp_pkg::*;

   localparam int HALF_W = ADDR_W - 1;

   logic [ADDR_W-1:0] alt_tap;
   logic [ADDR_W-1:0] split_tap;
   logic [ADDR_W-1:0] own_base;
   logic              known;

   assign known     = xfer_valid && kind_known(xfer_kind);
   assign split_tap = {~ptr[ADDR_W-1], xfer_tap[HALF_W-1:0]};
   assign own_base  = {ptr[ADDR_W-1], {HALF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         alt_tap <= {1'b1, {HALF_W{1'b0}}};
      end else if (known && !kind_split(xfer_kind)) begin
         ptr     <= xfer_tap;
         alt_tap <= {~xfer_tap[ADDR_W-1], {HALF_W{1'b0}}};
      end else if (known) begin
         if (ser_en && at_edge) begin
            ptr     <= split_tap;
            alt_tap <= own_base;
         end else begin
            if (ser_en) ptr <= ptr + 1'b1;
            alt_tap <= split_tap;
         end
      end else if (ser_en) begin
         if (at_edge) begin
            ptr     <= alt_tap;
            alt_tap <= own_base;
         end else begin
            ptr     <= ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sbp_ctrl.sv
module sbp_ctrl #(
   parameter int ADDR_W      = 9,
   parameter int STOP_LEVELS = 5,
   parameter int CODE_W      = (STOP_LEVELS > 4) ? $clog2(STOP_LEVELS) : 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en,
   input  logic              xfer_valid,
   input  logic [2:0]        xfer_kind,
   input  logic [ADDR_W-1:0] xfer_tap,
   input  logic              opt_set_stop,
   input  logic              opt_clear,
   input  logic [CODE_W-1:0] stop_code,
   output logic [ADDR_W-1:0] ptr,
   output logic              upper_half,
   output logic              port_is_out
);

   if (ADDR_W < 2) begin : g_bad_addr
      $fatal(1, "sbp_ctrl: ADDR_W must be at least 2");
   end
   if (STOP_LEVELS < 1 || STOP_LEVELS > ADDR_W - 1) begin : g_bad_levels
      $fatal(1, "sbp_ctrl: STOP_LEVELS out of range");
   end
   if ((1 << CODE_W) < STOP_LEVELS) begin : g_bad_code
      $fatal(1, "sbp_ctrl: CODE_W too narrow");
   end

   logic              split_on;
   logic              stop_on;
   logic [CODE_W-1:0] stop_sel;
   logic              at_edge;

   sbp_mode_reg #(.STOP_LEVELS(STOP_LEVELS), .CODE_W(CODE_W)) i_mode (
      .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
      .opt_set_stop(opt_set_stop), .opt_clear(opt_clear), .stop_code(stop_code),
      .split_on(split_on), .stop_on(stop_on), .stop_sel(stop_sel),
      .port_is_out(port_is_out)
   );

   sbp_boundary #(.ADDR_W(ADDR_W), .STOP_LEVELS(STOP_LEVELS), .CODE_W(CODE_W)) i_bnd (
      .ptr(ptr), .split_on(split_on), .stop_on(stop_on), .stop_sel(stop_sel),
      .at_edge(at_edge)
   );

   sbp_pointer #(.ADDR_W(ADDR_W)) i_ptr (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .at_edge(at_edge),
      .xfer_valid(xfer_valid), .xfer_kind(xfer_kind), .xfer_tap(xfer_tap),
      .ptr(ptr)
   );

   assign upper_half = ptr[ADDR_W-1];

endmodule

// File: rtl/sbp_ctrl_chk.sv
module sbp_ctrl_chk #(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_en,
   input logic              xfer_valid,
   input logic [2:0]        xfer_kind,
   input logic [ADDR_W-1:0] xfer_tap,
   input logic [ADDR_W-1:0] ptr,
   input logic              upper_half,
   input logic              port_is_out,
   input logic              split_q
);

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_kind <= 3'd2) |=> (ptr == $past(xfer_tap)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_en && !xfer_valid) |=> $stable(ptr));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_en && !xfer_valid && !split_q) |=> (ptr == $past(ptr) + 1'b1));

   p_dir_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && (xfer_kind == 3'd0 || xfer_kind == 3'd3)) |=> port_is_out);

   p_dir_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && (xfer_kind == 3'd1 || xfer_kind == 3'd2 || xfer_kind == 3'd4))
      |=> !port_is_out);

   p_split_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && (xfer_kind == 3'd3 || xfer_kind == 3'd4) && !ser_en) |=> $stable(ptr));

   p_cross_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_en && !xfer_valid && split_q)
      |=> ((ptr == $past(ptr) + 1'b1) || (upper_half != $past(upper_half))));

   p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_kind > 3'd4 && !ser_en) |=> ($stable(ptr) && $stable(port_is_out)));

endmodule

bind sbp_ctrl sbp_ctrl_chk #(.ADDR_W(ADDR_W)) i_sbp_ctrl_chk (
   .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .xfer_valid(xfer_valid),
   .xfer_kind(xfer_kind), .xfer_tap(xfer_tap), .ptr(ptr),
   .upper_half(upper_half), .port_is_out(port_is_out), .split_q(split_on)
);

// File: tb/test_sbp_ctrl.sv
module test_sbp_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_en = 1'b0;
   logic       xfer_valid = 1'b0;
   logic [2:0] xfer_kind = 3'd0;
   logic [8:0] xfer_tap = '0;
   logic       opt_set_stop = 1'b0;
   logic       opt_clear = 1'b0;
   logic [2:0] stop_code = '0;
   logic [8:0] ptr;
   logic       upper_half;
   logic       port_is_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sbp_ctrl i_sbp_ctrl (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .xfer_valid(xfer_valid),
      .xfer_kind(xfer_kind), .xfer_tap(xfer_tap), .opt_set_stop(opt_set_stop),
      .opt_clear(opt_clear), .stop_code(stop_code), .ptr(ptr),
      .upper_half(upper_half), .port_is_out(port_is_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [2:0] k, input int tap);
      xfer_valid = 1'b1; xfer_kind = k; xfer_tap = 9'(tap);
      @(negedge clk);
      xfer_valid = 1'b0;
   endtask

   task automatic adv(input int n);
      ser_en = 1'b1;
      for (int i = 0; i < n; i++) @(negedge clk);
      ser_en = 1'b0;
   endtask

   task automatic set_stop(input int code);
      opt_set_stop = 1'b1; stop_code = 3'(code);
      @(negedge clk);
      opt_set_stop = 1'b0;
   endtask

   task automatic clear_opt();
      opt_clear = 1'b1;
      @(negedge clk);
      opt_clear = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 ptr", int'(ptr), 0);
      chk("R1 upper", int'(upper_half), 0);
      chk("R1 dir", int'(port_is_out), 0);
   endtask

   task automatic t_normal_wrap();
      xfer(3'd0, 500);
      chk("R2 load", int'(ptr), 500);
      chk("R5 read dir", int'(port_is_out), 1);
      adv(11);
      chk("R3 advance", int'(ptr), 511);
      chk("R8 upper", int'(upper_half), 1);
      adv(1);
      chk("R4 wrap", int'(ptr), 0);
      repeat (5) @(negedge clk);
      chk("R3 hold", int'(ptr), 0);
   endtask

   task automatic t_dir();
      xfer(3'd1, 77);
      chk("R2 write load", int'(ptr), 77);
      chk("R5 write dir", int'(port_is_out), 0);
      xfer(3'd0, 3);
      xfer(3'd2, 130);
      chk("R2 pseudo load", int'(ptr), 130);
      chk("R5 pseudo dir", int'(port_is_out), 0);
   endtask

   task automatic t_split();
      xfer(3'd0, 10);
      xfer(3'd3, 9'h020);
      chk("R6 ptr kept", int'(ptr), 10);
      chk("R8 lower", int'(upper_half), 0);
      adv(245);
      chk("R7 end of half", int'(ptr), 255);
      adv(1);
      chk("R7 jump tap", int'(ptr), 288);
      chk("R8 upper", int'(upper_half), 1);
      adv(223);
      chk("R7 upper end", int'(ptr), 511);
      adv(1);
      chk("R9 default base", int'(ptr), 0);
      chk("R8 back lower", int'(upper_half), 0);
   endtask

   task automatic t_stop();
      set_stop(2);
      xfer(3'd0, 5);
      xfer(3'd4, 9'h040);
      chk("R5 split write dir", int'(port_is_out), 0);
      adv(58);
      chk("R10 before stop", int'(ptr), 63);
      adv(1);
      chk("R10 stop jump", int'(ptr), 320);
      adv(63);
      chk("R10 upper part end", int'(ptr), 383);
      adv(1);
      chk("R9 stop default", int'(ptr), 0);
      clear_opt();
      xfer(3'd0, 5);
      xfer(3'd3, 9'h040);
      adv(59);
      chk("R11 no stop", int'(ptr), 64);
      set_stop(7);
      xfer(3'd0, 0);
      xfer(3'd3, 9'h007);
      adv(15);
      chk("R10 clamp end", int'(ptr), 15);
      adv(1);
      chk("R10 clamp jump", int'(ptr), 263);
      clear_opt();
   endtask

   task automatic t_ignore();
      xfer(3'd0, 200);
      xfer(3'd7, 9);
      chk("R12 ptr", int'(ptr), 200);
      chk("R12 dir", int'(port_is_out), 1);
      xfer(3'd5, 33);
      chk("R12 ptr k5", int'(ptr), 200);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normal_wrap();
      t_dir();
      t_split();
      t_stop();
      t_ignore();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule